// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Timer

This block turns a fast functional clock into the timing events that an SPI transfer engine needs. A power-of-two prescaler selected by a 3-bit code produces a slow tick. A segment counter counts those ticks to build three kinds of interval: the delay from chip-select assertion to the first clock edge (lead), the quiet interval between transfers (gap), and a run of serial clock periods. Every interval is the programmed field value plus two, measured in prescaled ticks.

The transfer engine starts one operation at a time with a single-cycle request. While the operation runs, the block reports rising and falling serial-clock strobes, the serial clock level and a done strobe for each delay. The 24-bit configuration word carries the divide value, the gap length and the lead length. It is sampled together with the prescaler code and the bit count when a request is accepted. Changes to these inputs during an operation therefore do not disturb it.

Top module: `spi_sclk_timer`

## Requirements
- R1: After a synchronous reset, sclk, busy and all four strobes are low.
- R2: The prescaler code s (0 to 7) makes one tick equal to P = 2^s functional-clock cycles. If a request is accepted at edge c, tick k falls in the cycle that ends at edge c + k*P.
- R3: With T = divide value + 2, each serial bit takes T ticks. The low phase lasts L = T - floor(T/2) ticks, then sclk_rise pulses. The high phase lasts floor(T/2) ticks, then sclk_fall pulses. The extra tick of an odd T goes to the low phase.
- R4: The divide value is cfg_word[7:0]. The gap length is cfg_word[15:8]. The lead length is cfg_word[23:16].
- R5: A lead operation pulses lead_done for one cycle on tick (lead length + 2) and then ends.
- R6: A gap operation pulses gap_done for one cycle on tick (gap length + 2) and then ends.
- R7: A clock operation runs bit_count bits, and a bit_count of zero runs one bit. The sclk level goes high at the edge after sclk_rise and low at the edge after sclk_fall. sclk is low whenever busy is low.
- R8: cfg_word, presc_sel and bit_count are captured only at the edge that accepts a request. Changes while busy have no effect on the running operation.
- R9: A request is accepted only when busy is low, and requests made while busy are dropped. When several requests arrive together, lead wins over clock, and clock wins over gap. busy is high from the accepting edge until the edge after the last tick.
- R10: At most one of sclk_rise, sclk_fall, lead_done and gap_done is high in any cycle. sclk_rise occurs only while sclk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 24 | Lead length [23:16], gap length [15:8], divide value [7:0] |
| presc_sel | input | 3 | Prescaler code, factor 2^code |
| bit_count | input | BITS_W | Serial bits for a clock operation (0 means 1) |
| start_lead | input | 1 | Request a chip-select-to-clock delay |
| start_clk | input | 1 | Request a run of serial clock bits |
| start_gap | input | 1 | Request a between-transfer delay |
| sclk | output | 1 | Serial clock level, idle low |
| sclk_rise | output | 1 | One-cycle strobe ending a low phase |
| sclk_fall | output | 1 | One-cycle strobe ending a high phase |
| lead_done | output | 1 | One-cycle strobe when the lead delay ends |
| gap_done | output | 1 | One-cycle strobe when the gap delay ends |
| busy | output | 1 | An operation is running |

## Verification
The clock runs use divide values 0, 1, 5 and 255 with prescaler codes 0, 3 and 7. Comparing even and odd T shows where the extra tick lands. The prescale factors separate tick spacing from phase counting, and the maximum divide value exposes any counter truncation. Lead and gap delays use lengths 0, 5 and 255, with non-zero values in the other fields, to show that each delay decodes only its own field. Mid-run changes to the inputs, requests made while busy and requests that collide are checked against the capture and priority rules.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    localparam int DIV_W = 8;               // width of each timing field
    localparam int PRE_W = 3;               // prescaler code width
    localparam int CFG_W = 3 * DIV_W;       // whole configuration word
    localparam int SEG_W = DIV_W + 1;       // field + 2 needs one more bit

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LEAD = 2'd1,
        OP_CLK  = 2'd2,
        OP_GAP  = 2'd3
    } op_e;

    // Field order is behaviour: the transfer engine packs the word this way.
    typedef struct packed {
        logic [DIV_W-1:0] lead;   // [23:16]
        logic [DIV_W-1:0] gap;    // [15:8]
        logic [DIV_W-1:0] div;    // [7:0]
    } cfg_t;

    function automatic logic [SEG_W-1:0] seg_len(input logic [DIV_W-1:0] v);
        return SEG_W'(v) + SEG_W'(2);
    endfunction

    function automatic logic [SEG_W-1:0] high_len(input logic [DIV_W-1:0] v);
        return seg_len(v) >> 1;
    endfunction

    function automatic logic [SEG_W-1:0] low_len(input logic [DIV_W-1:0] v);
        return seg_len(v) - high_len(v);
    endfunction

endpackage

// File: rtl/spi_presc_tick.sv
module spi_presc_tick
    import spi_clkdiv_pkg::*;
#(
    parameter int SEL_W = PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int PC_W = (1 << SEL_W) - 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] mask_q;
    logic [PC_W-1:0] mask_d;

    generate
        for (genvar i = 0; i < PC_W; i++) begin : g_mask
            assign mask_d[i] = (SEL_W'(i) < sel);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            mask_q <= '0;
        end else if (clear) begin
            pc_q   <= '0;
            mask_q <= mask_d;
        end else if (run) begin
            pc_q   <= (pc_q == mask_q) ? '0 : pc_q + 1'b1;
        end
    end

    assign tick = run && (pc_q == mask_q);

    AST_PC_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (pc_q <= mask_q)); // R2

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        clear |-> !run); // R9

endmodule

// File: rtl/spi_clk_seq.sv
module spi_clk_seq
    import spi_clkdiv_pkg::*;
#(
    parameter int BITS_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  cfg_t              cfg_in,
    input  logic [BITS_W-1:0] bits_in,
    input  logic              start_lead,
    input  logic              start_clk,
    input  logic              start_gap,
    output logic              accept,
    output logic              busy,
    output logic              sclk,
    output logic              sclk_rise,
    output logic              sclk_fall,
    output logic              lead_done,
    output logic              gap_done
);

    op_e               op_q;
    op_e               op_nxt;
    cfg_t              cfg_q;
    logic [SEG_W-1:0]  tcnt_q;
    logic [SEG_W-1:0]  limit;
    logic              phase_q;     // 0: low phase, 1: high phase
    logic              sclk_q;
    logic [BITS_W-1:0] bits_q;
    logic              seg_end;

    always_comb begin
        if (start_lead)      op_nxt = OP_LEAD;
        else if (start_clk)  op_nxt = OP_CLK;
        else if (start_gap)  op_nxt = OP_GAP;
        else                 op_nxt = OP_IDLE;
    end

    assign busy   = (op_q != OP_IDLE);
    assign accept = !busy && (op_nxt != OP_IDLE);

    always_comb begin
        case (op_q)
            OP_LEAD: limit = seg_len(cfg_q.lead);
            OP_GAP:  limit = seg_len(cfg_q.gap);
            OP_CLK:  limit = phase_q ? high_len(cfg_q.div) : low_len(cfg_q.div);
            default: limit = '1;
        endcase
    end

    assign seg_end   = tick && busy && (tcnt_q == limit - 1'b1);
    assign sclk_rise = seg_end && (op_q == OP_CLK) && !phase_q;
    assign sclk_fall = seg_end && (op_q == OP_CLK) &&  phase_q;
    assign lead_done = seg_end && (op_q == OP_LEAD);
    assign gap_done  = seg_end && (op_q == OP_GAP);
    assign sclk      = sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_IDLE;
            cfg_q   <= '0;
            tcnt_q  <= '0;
            phase_q <= 1'b0;
            sclk_q  <= 1'b0;
            bits_q  <= '0;
        end else if (accept) begin
            op_q    <= op_nxt;
            cfg_q   <= cfg_in;
            bits_q  <= (bits_in == '0) ? BITS_W'(1) : bits_in;
            tcnt_q  <= '0;
            phase_q <= 1'b0;
            sclk_q  <= 1'b0;
        end else if (busy && tick) begin
            if (seg_end) begin
                tcnt_q <= '0;
                if (op_q == OP_CLK) begin
                    phase_q <= !phase_q;
                    sclk_q  <= !phase_q;
                    if (phase_q) begin
                        if (bits_q == BITS_W'(1)) op_q <= OP_IDLE;
                        else                      bits_q <= bits_q - 1'b1;
                    end
                end else begin
                    op_q <= OP_IDLE;
                end
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sclk_rise, sclk_fall, lead_done, gap_done})); // R10

    AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |-> !sclk_q); // R10

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk_q); // R7

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tcnt_q < limit)); // R3

    AST_DELAY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (lead_done || gap_done) |=> !busy); // R5

endmodule

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer
    import spi_clkdiv_pkg::*;
#(
    parameter int BITS_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [PRE_W-1:0]  presc_sel,
    input  logic [BITS_W-1:0] bit_count,
    input  logic              start_lead,
    input  logic              start_clk,
    input  logic              start_gap,
    output logic              sclk,
    output logic              sclk_rise,
    output logic              sclk_fall,
    output logic              lead_done,
    output logic              gap_done,
    output logic              busy
);

    cfg_t cfg_s;
    logic tick;
    logic accept;

    assign cfg_s = cfg_t'(cfg_word);

    spi_presc_tick #(.SEL_W(PRE_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .run   (busy),
        .sel   (presc_sel),
        .tick  (tick)
    );

    spi_clk_seq #(.BITS_W(BITS_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cfg_in     (cfg_s),
        .bits_in    (bit_count),
        .start_lead (start_lead),
        .start_clk  (start_clk),
        .start_gap  (start_gap),
        .accept     (accept),
        .busy       (busy),
        .sclk       (sclk),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .lead_done  (lead_done),
        .gap_done   (gap_done)
    );

endmodule

// File: tb/tb_spi_sclk_timer.sv
module tb_spi_sclk_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] cfg_word = '0;
    logic [2:0]  presc_sel = '0;
    logic [5:0]  bit_count = '0;
    logic        start_lead = 1'b0;
    logic        start_clk = 1'b0;
    logic        start_gap = 1'b0;
    logic        sclk, sclk_rise, sclk_fall, lead_done, gap_done, busy;

    spi_sclk_timer #(.BITS_W(6)) dut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .presc_sel(presc_sel),
        .bit_count(bit_count), .start_lead(start_lead), .start_clk(start_clk),
        .start_gap(start_gap), .sclk(sclk), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .lead_done(lead_done), .gap_done(gap_done),
        .busy(busy)
    );

    always #4 clk = !clk;   // 125 MHz

    int    checks = 0;
    int    errors = 0;
    string tag_s  = "R1";
    bit    done_f = 0;

    // behavioural reference state
    int cyc = 0;
    int m_op = 0;           // 0 none, 1 lead, 2 clock, 3 gap
    int m_c = 0, m_p = 1, m_t = 2, m_l = 1, m_total = 0, m_len = 0;
    int busy_end = -10;
    bit e_rise, e_fall, e_lead, e_gap, e_busy, e_sclk;
    bit prev_rise, prev_fall;

    always @(posedge clk) begin
        cyc = cyc + 1;
        e_rise = 0; e_fall = 0; e_lead = 0; e_gap = 0; e_busy = 0;
        if (rst) begin
            m_op = 0; busy_end = -10; e_sclk = 0; prev_rise = 0; prev_fall = 0;
        end else begin
            if (prev_rise) e_sclk = 1;
            if (prev_fall) e_sclk = 0;
            if ((cyc - 1 > busy_end) && (start_lead || start_clk || start_gap)) begin
                m_op = start_lead ? 1 : (start_clk ? 2 : 3);
                m_c  = cyc;
                m_p  = 1 << presc_sel;
                m_t  = int'(cfg_word[7:0]) + 2;
                m_l  = m_t - m_t / 2;
                if (m_op == 1)      m_total = int'(cfg_word[23:16]) + 2;
                else if (m_op == 3) m_total = int'(cfg_word[15:8]) + 2;
                else begin
                    m_len   = (bit_count == 0) ? 1 : int'(bit_count);
                    m_total = m_len * m_t;
                end
                busy_end = m_c + m_total * m_p - 1;
            end
            if (m_op != 0 && cyc >= m_c && cyc <= busy_end) begin
                int off;
                e_busy = 1;
                off = cyc - m_c + 1;
                if (off % m_p == 0) begin
                    int k, b, r;
                    k = off / m_p;
                    if (m_op == 1 && k == m_total) e_lead = 1;
                    if (m_op == 3 && k == m_total) e_gap  = 1;
                    if (m_op == 2) begin
                        b = (k - 1) / m_t;
                        r = k - b * m_t;
                        if (r == m_l) e_rise = 1;
                        if (r == m_t) e_fall = 1;
                    end
                end
            end
            prev_rise = e_rise;
            prev_fall = e_fall;
        end
    end

    task automatic chk(input string sig, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag_s, sig, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (cyc > 0 && !done_f) begin
            chk("sclk", sclk, e_sclk);
            chk("sclk_rise", sclk_rise, e_rise);
            chk("sclk_fall", sclk_fall, e_fall);
            chk("lead_done", lead_done, e_lead);
            chk("gap_done", gap_done, e_gap);
            chk("busy", busy, e_busy);
        end
    end

    task automatic wait_idle();
        while (cyc <= busy_end + 1) @(negedge clk);
        @(negedge clk);
    endtask

    // kind: 1 lead, 2 clock, 3 gap
    task automatic run_op(input int kind, input logic [23:0] cfg, input logic [2:0] sel,
                          input logic [5:0] nb, input string tag);
        @(negedge clk);
        tag_s = tag;
        cfg_word = cfg; presc_sel = sel; bit_count = nb;
        start_lead = (kind == 1); start_clk = (kind == 2); start_gap = (kind == 3);
        @(negedge clk);
        start_lead = 0; start_clk = 0; start_gap = 0;
        wait_idle();
    endtask

    task automatic finish_run();
        done_f = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done_f) begin
            checks++; errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset state observed for several cycles
        tag_s = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);

        // R3: even and odd T, prescale 1
        run_op(2, 24'h00_00_00, 3'd0, 6'd1, "R3");
        run_op(2, 24'h00_00_01, 3'd0, 6'd2, "R3");
        run_op(2, 24'h00_00_FF, 3'd0, 6'd1, "R3");
        // R2: prescale factors
        run_op(2, 24'h00_00_05, 3'd3, 6'd2, "R2");
        run_op(2, 24'h00_00_00, 3'd7, 6'd1, "R2");
        run_op(2, 24'h00_00_02, 3'd1, 6'd3, "R2");
        // R4: other fields non-zero must not affect the divide value
        run_op(2, 24'h7F_33_04, 3'd0, 6'd2, "R4");
        run_op(1, 24'h03_C8_FE, 3'd0, 6'd1, "R4");
        run_op(3, 24'hD0_02_FF, 3'd0, 6'd1, "R4");
        // R5: lead delays
        run_op(1, 24'h00_00_00, 3'd0, 6'd1, "R5");
        run_op(1, 24'h05_00_00, 3'd2, 6'd1, "R5");
        run_op(1, 24'hFF_00_00, 3'd1, 6'd1, "R5");
        // R6: gap delays
        run_op(3, 24'h00_00_00, 3'd0, 6'd1, "R6");
        run_op(3, 24'h00_05_00, 3'd2, 6'd1, "R6");
        run_op(3, 24'h00_FF_00, 3'd1, 6'd1, "R6");
        // R7: bit count zero runs one bit, longer run
        run_op(2, 24'h00_00_03, 3'd0, 6'd0, "R7");
        run_op(2, 24'h00_00_01, 3'd1, 6'd5, "R7");

        // R8: change inputs while a clock run is busy
        @(negedge clk);
        tag_s = "R8";
        cfg_word = 24'h00_00_03; presc_sel = 3'd1; bit_count = 6'd3; start_clk = 1;
        @(negedge clk);
        start_clk = 0;
        repeat (4) @(negedge clk);
        cfg_word = 24'h11_22_09; presc_sel = 3'd4; bit_count = 6'd9;
        // R9: a request while busy is dropped
        tag_s = "R9";
        start_gap = 1;
        @(negedge clk);
        start_gap = 0;
        wait_idle();

        // R9: simultaneous requests, lead over clock over gap
        @(negedge clk);
        cfg_word = 24'h02_04_01; presc_sel = 3'd0; bit_count = 6'd1;
        start_lead = 1; start_clk = 1; start_gap = 1;
        @(negedge clk);
        start_lead = 0; start_clk = 0; start_gap = 0;
        wait_idle();
        @(negedge clk);
        start_clk = 1; start_gap = 1;
        @(negedge clk);
        start_clk = 0; start_gap = 0;
        wait_idle();

        // R10: back-to-back sequence lead, clock, gap
        run_op(1, 24'h01_01_01, 3'd0, 6'd2, "R10");
        run_op(2, 24'h01_01_01, 3'd0, 6'd2, "R10");
        run_op(3, 24'h01_01_01, 3'd0, 6'd2, "R10");

        // R1: reset in the middle of a run
        @(negedge clk);
        tag_s = "R1";
        cfg_word = 24'h00_00_08; start_clk = 1; bit_count = 6'd4;
        @(negedge clk);
        start_clk = 0;
        repeat (5) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);

        finish_run();
    end

endmodule